// File: doc/BRIEF.md
# Five-Channel Masked-Compare Timer

This block is a timer peripheral with a 32-bit free-running count and a small set of compare channels. Software reaches it through a simple word-wide register port. It can load or read the count, arm channels, and program per-channel compare and mask values. It also handles interrupt status, with one address that sets status bits and another that clears them. Each channel compares the upper bits of the count with its compare value, counting only the bit positions its mask selects. A channel matches when every selected position agrees.

On each clock, a match sets that channel's status bit if the channel's interrupt enable is on. A channel's interrupt line is high while its status bit and its mask bit are both one. Each channel also drives an output pin while its output enable is set. The pin takes the programmed level while the channel matches and the opposite level while it does not. The count advances on an external tick enable, so any prescaling is done outside the block.

Top module: `chan_cmp_timer`

## Requirements
- R1: After reset, every register reads zero, all pins are low and all interrupt lines are low.
- R2: Word registers sit at these offsets: enable 0x10, level 0x14, interrupt mask 0x18, interrupt enable 0x24, compare 0x80+4n and compare mask 0xC0+4n for channel n. Enable, level, compare and compare-mask registers keep only bits 31..27 of a write, and read the other bits as zero. Channel n owns bit 31-n of the enable and level registers. The interrupt mask, status and enable registers keep only bits 15..11, and channel n owns bit 15-n.
- R3: A word write to 0x00 loads the count, and a word read of 0x00 returns it. Otherwise the count increases by one on each clock where tick_en is high, and wraps from 0xFFFFFFFF to 0. A load takes priority over a tick in the same cycle.
- R4: A word write to 0x1C ORs the kept data bits into the status register. A word write to 0x20 clears the status bits where the kept data bits are one. A word read of either address returns the status register.
- R5: Channel n matches when the count's bits 31..27 AND the compare mask equal the compare value AND the compare mask. On every clock where channel n matches and its interrupt enable bit is one, its status bit is set. This set takes priority over a clear in the same cycle.
- R6: irq_out[n] is high exactly when status bit 15-n and interrupt mask bit 15-n are both one. The line follows the registered state with no added delay.
- R7: While the enable bit of channel n is one, pin_out[n] loads, at each clock, the channel's level bit if the channel matches and the inverted level bit if it does not. While the enable bit is zero, the pin holds its value.
- R8: An access with size other than word (req_size 0 = byte, 1 = halfword, 2 = word) reads all ones, and its write changes nothing. A word access to any other offset, including an offset that is not a multiple of four, also reads all ones and its write changes nothing. rd_data is all ones whenever no word read of a mapped offset is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count advance enable |
| req_valid | input | 1 | Register access presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the access |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, same cycle as the request |
| pin_out | output | 5 | Channel output pins, channel n on bit n |
| irq_out | output | 5 | Channel interrupt lines, channel n on bit n |

## Verification
The bench targets a status clear that lands in the same cycle as an enabled match. A design that gets the priority wrong drops a status bit that should stay set. It also loads the count with all ones and then ticks it, which catches a count that saturates or skips zero on the wrap. Byte, halfword and misaligned accesses check that narrow writes change no register and that their reads return all ones instead of a register value. Random masks keep only a few bits, so the bench sees both matching and mismatching channels. Any pin that flips while its enable is off, or that takes the wrong polarity, is then reported.

// File: rtl/chan_cmp_timer_pkg.sv
package chan_cmp_timer_pkg;
   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;

   localparam logic [7:0] OFS_COUNT = 8'h00;
   localparam logic [7:0] OFS_OE    = 8'h10;
   localparam logic [7:0] OFS_LVL   = 8'h14;
   localparam logic [7:0] OFS_IMSK  = 8'h18;
   localparam logic [7:0] OFS_SSET  = 8'h1C;
   localparam logic [7:0] OFS_SCLR  = 8'h20;
   localparam logic [7:0] OFS_IEN   = 8'h24;
   localparam logic [7:0] OFS_CMP0  = 8'h80;
   localparam logic [7:0] OFS_MSK0  = 8'hC0;
endpackage

// File: rtl/cct_regs.sv
module cct_regs
   import chan_cmp_timer_pkg::*;
#(
   parameter int NCH    = 5,
   parameter int DW     = 32,
   parameter int CMP_W  = 5,
   parameter int STS_HI = 15,
   parameter int AW     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_en,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [AW-1:0]        req_addr,
   input  logic [1:0]           req_size,
   input  logic [DW-1:0]        req_wdata,
   input  logic [NCH-1:0]       sts_i,
   output logic [DW-1:0]        count_o,
   output logic [NCH-1:0]       oe_o,
   output logic [NCH-1:0]       lvl_o,
   output logic [NCH-1:0]       imsk_o,
   output logic [NCH-1:0]       ien_o,
   output logic [NCH*CMP_W-1:0] cmp_o,
   output logic [NCH*CMP_W-1:0] msk_o,
   output logic [NCH-1:0]       sset_o,
   output logic [NCH-1:0]       sclr_o,
   output logic [DW-1:0]        rd_data
);
   localparam int STRIDE = 4;

   if (NCH < 1 || NCH > DW) $error("cct_regs: NCH out of range");
   if (CMP_W < 1 || CMP_W > DW) $error("cct_regs: CMP_W out of range");
   if (STS_HI + 1 < NCH || STS_HI >= DW) $error("cct_regs: STS_HI does not fit");
   if (int'(OFS_CMP0) + STRIDE*NCH > int'(OFS_MSK0)) $error("cct_regs: compare bank overlaps mask bank");
   if (int'(OFS_MSK0) + STRIDE*NCH > (1 << AW)) $error("cct_regs: mask bank exceeds address space");

   logic          wr_word, rd_word;
   logic [NCH-1:0] hit_cmp, hit_msk;
   logic [NCH-1:0] wd_hi, wd_sts;
   logic [CMP_W-1:0] wd_fld;

   assign wr_word = req_valid &&  req_write && (req_size == SZ_WORD);
   assign rd_word = req_valid && !req_write && (req_size == SZ_WORD);
   assign wd_fld  = req_wdata[DW-1 -: CMP_W];

   for (genvar n = 0; n < NCH; n++) begin : g_dec
      assign hit_cmp[n] = (req_addr == AW'(int'(OFS_CMP0) + STRIDE*n));
      assign hit_msk[n] = (req_addr == AW'(int'(OFS_MSK0) + STRIDE*n));
      assign wd_hi[n]   = req_wdata[DW-1-n];
      assign wd_sts[n]  = req_wdata[STS_HI-n];
   end

   assign sset_o = (wr_word && req_addr == OFS_SSET) ? wd_sts : '0;
   assign sclr_o = (wr_word && req_addr == OFS_SCLR) ? wd_sts : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_o <= '0;
      end else if (wr_word && req_addr == OFS_COUNT) begin
         count_o <= req_wdata;
      end else if (tick_en) begin
         count_o <= count_o + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oe_o   <= '0;
         lvl_o  <= '0;
         imsk_o <= '0;
         ien_o  <= '0;
      end else if (wr_word) begin
         if (req_addr == OFS_OE)   oe_o   <= wd_hi;
         if (req_addr == OFS_LVL)  lvl_o  <= wd_hi;
         if (req_addr == OFS_IMSK) imsk_o <= wd_sts;
         if (req_addr == OFS_IEN)  ien_o  <= wd_sts;
      end
   end

   for (genvar n = 0; n < NCH; n++) begin : g_bank
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cmp_o[n*CMP_W +: CMP_W] <= '0;
            msk_o[n*CMP_W +: CMP_W] <= '0;
         end else if (wr_word) begin
            if (hit_cmp[n]) cmp_o[n*CMP_W +: CMP_W] <= wd_fld;
            if (hit_msk[n]) msk_o[n*CMP_W +: CMP_W] <= wd_fld;
         end
      end
   end

   function automatic logic [DW-1:0] pack_hi(input logic [NCH-1:0] v);
      logic [DW-1:0] r;
      r = '0;
      for (int i = 0; i < NCH; i++) r[DW-1-i] = v[i];
      return r;
   endfunction

   function automatic logic [DW-1:0] pack_sts(input logic [NCH-1:0] v);
      logic [DW-1:0] r;
      r = '0;
      for (int i = 0; i < NCH; i++) r[STS_HI-i] = v[i];
      return r;
   endfunction

   always_comb begin
      rd_data = '1;
      if (rd_word) begin
         unique case (req_addr)
            OFS_COUNT:           rd_data = count_o;
            OFS_OE:              rd_data = pack_hi(oe_o);
            OFS_LVL:             rd_data = pack_hi(lvl_o);
            OFS_IMSK:            rd_data = pack_sts(imsk_o);
            OFS_SSET, OFS_SCLR:  rd_data = pack_sts(sts_i);
            OFS_IEN:             rd_data = pack_sts(ien_o);
            default: begin
               for (int i = 0; i < NCH; i++) begin
                  if (hit_cmp[i]) rd_data = {cmp_o[i*CMP_W +: CMP_W], {(DW-CMP_W){1'b0}}};
                  if (hit_msk[i]) rd_data = {msk_o[i*CMP_W +: CMP_W], {(DW-CMP_W){1'b0}}};
               end
            end
         endcase
      end
   end

   // R3: without a load, a tick advances the count by exactly one
   a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !(wr_word && req_addr == OFS_COUNT)) |=> count_o == $past(count_o) + 1'b1);

   // R3: the count holds when neither tick nor load
   a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !(wr_word && req_addr == OFS_COUNT)) |=> $stable(count_o));

   // R8: narrow reads return all ones
   a_r8_narrow_read: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_size != SZ_WORD) |-> rd_data == '1);

   // R8: narrow writes leave configuration untouched
   a_r8_narrow_write: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_size != SZ_WORD) |=>
         $stable(oe_o) && $stable(lvl_o) && $stable(imsk_o) && $stable(ien_o)
         && $stable(cmp_o) && $stable(msk_o));
endmodule

// File: rtl/cct_chan.sv
module cct_chan #(
   parameter int CMP_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CMP_W-1:0] count_top,
   input  logic [CMP_W-1:0] cmp_i,
   input  logic [CMP_W-1:0] msk_i,
   input  logic             oe_i,
   input  logic             lvl_i,
   input  logic             ien_i,
   input  logic             imsk_i,
   input  logic             sset_i,
   input  logic             sclr_i,
   output logic             sts_o,
   output logic             pin_o,
   output logic             irq_o
);
   logic hit;
   logic hit_armed;

   assign hit       = ((count_top ^ cmp_i) & msk_i) == '0;
   assign hit_armed = hit && ien_i;

   always_ff @(posedge clk) begin
      if (!rst_n) sts_o <= 1'b0;
      else        sts_o <= ((sts_o | sset_i) & ~sclr_i) | hit_armed;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    pin_o <= 1'b0;
      else if (oe_i) pin_o <= hit ? lvl_i : ~lvl_i;
   end

   assign irq_o = sts_o & imsk_i;

   // R5: an armed match leaves the status bit set, whatever else happens
   a_r5_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
      hit_armed |=> sts_o);

   // R4: a set request is never lost
   a_r4_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      sset_i |=> sts_o);

   // R4: a clear without a competing armed match empties the bit
   a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (sclr_i && !hit_armed) |=> !sts_o);

   // R7: a disabled channel keeps its pin
   a_r7_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_i |=> $stable(pin_o));

   // R7: an enabled channel follows level on match, inverse otherwise
   a_r7_pin_drive: assert property (@(posedge clk) disable iff (!rst_n)
      oe_i |=> pin_o == ($past(hit) ? $past(lvl_i) : !$past(lvl_i)));
endmodule

// File: rtl/chan_cmp_timer.sv
module chan_cmp_timer #(
   parameter int NCH    = 5,
   parameter int DW     = 32,
   parameter int CMP_W  = 5,
   parameter int STS_HI = 15,
   parameter int AW     = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick_en,
   input  logic           req_valid,
   input  logic           req_write,
   input  logic [AW-1:0]  req_addr,
   input  logic [1:0]     req_size,
   input  logic [DW-1:0]  req_wdata,
   output logic [DW-1:0]  rd_data,
   output logic [NCH-1:0] pin_out,
   output logic [NCH-1:0] irq_out
);
   logic [DW-1:0]        count;
   logic [NCH-1:0]       oe, lvl, imsk, ien, sset, sclr, sts;
   logic [NCH*CMP_W-1:0] cmp_all, msk_all;
   logic [CMP_W-1:0]     count_top;

   assign count_top = count[DW-1 -: CMP_W];

   cct_regs #(.NCH(NCH), .DW(DW), .CMP_W(CMP_W), .STS_HI(STS_HI), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_size(req_size), .req_wdata(req_wdata), .sts_i(sts),
      .count_o(count), .oe_o(oe), .lvl_o(lvl), .imsk_o(imsk), .ien_o(ien),
      .cmp_o(cmp_all), .msk_o(msk_all), .sset_o(sset), .sclr_o(sclr),
      .rd_data(rd_data)
   );

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      cct_chan #(.CMP_W(CMP_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .count_top(count_top),
         .cmp_i(cmp_all[n*CMP_W +: CMP_W]), .msk_i(msk_all[n*CMP_W +: CMP_W]),
         .oe_i(oe[n]), .lvl_i(lvl[n]), .ien_i(ien[n]), .imsk_i(imsk[n]),
         .sset_i(sset[n]), .sclr_i(sclr[n]),
         .sts_o(sts[n]), .pin_o(pin_out[n]), .irq_o(irq_out[n])
      );
   end

   // R1: nothing is pending or driven in the first cycle after reset
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> (irq_out == '0 && pin_out == '0));
endmodule

// File: tb/chan_cmp_timer_bench.sv
`timescale 1ns/1ps
module chan_cmp_timer_bench;
   localparam int NCH = 5;
   localparam logic [31:0] HI_M  = 32'hF800_0000;
   localparam logic [31:0] STS_M = 32'h0000_F800;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [1:0]  req_size = 2'd2;
   logic [31:0] req_wdata = '0;
   logic [31:0] rd_data;
   logic [4:0]  pin_out, irq_out;

   int nvec = 0;
   int nfail = 0;

   logic [31:0] m_tb, m_oe, m_ol, m_im, m_st, m_ie;
   logic [31:0] m_cmp [NCH];
   logic [31:0] m_msk [NCH];
   logic [4:0]  m_pin;

   always #4 clk = ~clk;

   chan_cmp_timer u_chan_cmp_timer (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req_valid(req_valid),
      .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
      .req_wdata(req_wdata), .rd_data(rd_data), .pin_out(pin_out), .irq_out(irq_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_tb = '0; m_oe = '0; m_ol = '0; m_im = '0; m_st = '0; m_ie = '0; m_pin = '0;
      for (int n = 0; n < NCH; n++) begin m_cmp[n] = '0; m_msk[n] = '0; end
   endtask

   function automatic logic [31:0] exp_read(input logic [7:0] a, input logic [1:0] s);
      if (s != 2'd2) return '1;
      case (a)
         8'h00: return m_tb;
         8'h10: return m_oe;
         8'h14: return m_ol;
         8'h18: return m_im;
         8'h1C, 8'h20: return m_st;
         8'h24: return m_ie;
         default: begin
            for (int n = 0; n < NCH; n++) begin
               if (a == 8'h80 + 8'(4*n)) return m_cmp[n];
               if (a == 8'hC0 + 8'(4*n)) return m_msk[n];
            end
            return '1;
         end
      endcase
   endfunction

   function automatic string tag_of(input logic [7:0] a, input logic [1:0] s);
      if (s != 2'd2 || exp_read(a, s) === '1 && !(a inside {8'h00,8'h10,8'h14,8'h18,8'h1C,8'h20,8'h24}) && a[1:0] != 0)
         return "R8";
      if (a == 8'h00) return "R3";
      if (a == 8'h1C || a == 8'h20) return "R4";
      return "R2";
   endfunction

   function automatic logic model_hit(input int n);
      return ((m_tb & m_msk[n] & HI_M) == (m_cmp[n] & m_msk[n] & HI_M));
   endfunction

   task automatic cyc(input logic v, input logic w, input logic [7:0] a, input logic [1:0] s,
                      input logic [31:0] d, input logic t, input string tag);
      logic [31:0] n_tb, n_st;
      logic [4:0]  n_pin, exp_irq;
      logic        ww;
      @(negedge clk);
      req_valid = v; req_write = w; req_addr = a; req_size = s; req_wdata = d; tick_en = t;
      #1;
      for (int n = 0; n < NCH; n++) exp_irq[n] = m_st[15-n] & m_im[15-n];
      chk("R6 irq_out", 32'(irq_out), 32'(exp_irq));
      chk("R7 pin_out", 32'(pin_out), 32'(m_pin));
      if (v && !w) chk((tag == "") ? tag_of(a, s) : tag, rd_data, exp_read(a, s));
      if (!v) chk("R8 idle rd_data", rd_data, '1);
      ww = v && w && (s == 2'd2);
      n_tb = (ww && a == 8'h00) ? d : m_tb + 32'(t);
      n_pin = m_pin;
      n_st = m_st;
      if (ww && a == 8'h1C) n_st = n_st | (d & STS_M);
      if (ww && a == 8'h20) n_st = n_st & ~(d & STS_M);
      for (int n = 0; n < NCH; n++) begin
         if (m_oe[31-n]) n_pin[n] = model_hit(n) ? m_ol[31-n] : !m_ol[31-n];
         if (model_hit(n) && m_ie[15-n]) n_st[15-n] = 1'b1;
      end
      @(posedge clk);
      m_tb = n_tb; m_pin = n_pin; m_st = n_st;
      if (ww) begin
         if (a == 8'h10) m_oe = d & HI_M;
         if (a == 8'h14) m_ol = d & HI_M;
         if (a == 8'h18) m_im = d & STS_M;
         if (a == 8'h24) m_ie = d & STS_M;
         for (int n = 0; n < NCH; n++) begin
            if (a == 8'h80 + 8'(4*n)) m_cmp[n] = d & HI_M;
            if (a == 8'hC0 + 8'(4*n)) m_msk[n] = d & HI_M;
         end
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      cyc(1'b1, 1'b1, a, 2'd2, d, 1'b0, "");
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      cyc(1'b1, 1'b0, a, 2'd2, '0, 1'b0, tag);
   endtask

   function automatic logic [7:0] pick_addr();
      int k;
      k = int'($urandom % 16);
      case (k)
         0: return 8'h00;  1: return 8'h10;  2: return 8'h14;  3: return 8'h18;
         4: return 8'h1C;  5: return 8'h20;  6: return 8'h24;
         7, 8: return 8'h80 + 8'(4 * ($urandom % 5));
         9, 10: return 8'hC0 + 8'(4 * ($urandom % 5));
         default: return 8'($urandom);
      endcase
   endfunction

   initial begin
      #(8 * 150000);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      logic [7:0] a;
      logic [31:0] d;
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1: reset state visible at the ports
      rd(8'h10, "R1"); rd(8'h18, "R1"); rd(8'h1C, "R1"); rd(8'h84, "R1"); rd(8'hC4, "R1");
      rd(8'h00, "R1");
      // R2: only the kept field survives a write of all ones
      wr(8'h14, '1); rd(8'h14, "R2");
      wr(8'h18, '1); rd(8'h18, "R2");
      wr(8'h90, '1); rd(8'h90, "R2");
      // R3: load then wrap
      cyc(1'b1, 1'b1, 8'h00, 2'd2, 32'hFFFF_FFFF, 1'b1, "");
      cyc(1'b1, 1'b0, 8'h00, 2'd2, '0, 1'b1, "R3");
      rd(8'h00, "R3");
      // R8: narrow and misaligned accesses
      cyc(1'b1, 1'b1, 8'h10, 2'd0, '1, 1'b0, "");
      cyc(1'b1, 1'b1, 8'h10, 2'd1, '1, 1'b0, "");
      rd(8'h10, "R8");
      cyc(1'b1, 1'b0, 8'h14, 2'd1, '0, 1'b0, "R8");
      wr(8'h12, '1); rd(8'h12, "R8"); rd(8'h10, "R8");
      // R4: set then clear via separate addresses
      wr(8'h24, '0); wr(8'h1C, 32'h0000_A800); rd(8'h20, "R4");
      wr(8'h20, 32'h0000_2000); rd(8'h1C, "R4");
      // R5: armed match beats a same-cycle clear
      wr(8'h00, 32'h0000_0000); wr(8'hC0, HI_M); wr(8'h80, '0); wr(8'h24, 32'h0000_8000);
      wr(8'h20, 32'h0000_8000); rd(8'h1C, "R5");
      wr(8'h24, '0); wr(8'h20, STS_M); rd(8'h1C, "R5");
      // R7: enabled pin with level 1 while matching, then mismatch
      wr(8'h14, 32'h8000_0000); wr(8'h10, 32'h8000_0000); rd(8'h10, "R7");
      wr(8'h00, 32'h0800_0000); rd(8'h00, "R7"); rd(8'h00, "R7");
      wr(8'h10, '0); wr(8'h00, 32'h0); rd(8'h00, "R7");
      // random mix
      for (int i = 0; i < 4000; i++) begin
         a = pick_addr();
         d = $urandom;
         if (a >= 8'hC0) d = d & $urandom & $urandom;
         cyc(($urandom % 8) != 0, $urandom % 2 == 0, a,
             (($urandom % 8) == 0) ? 2'($urandom % 2) : 2'd2, d, $urandom % 2 == 0, "");
      end
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule